// File: doc/BRIEF.md
# Interrupt Rate Throttling Timer

This block sits between a device's interrupt-cause logic and its single host interrupt line. It enforces a programmable minimum gap between successive interrupt assertions. The gap length comes from a 16-bit interval held in one 32-bit register word. One interval unit is a fixed 256 ns tick, which a free-running prescaler derives from the core clock. For example, an interval of 500 keeps the host free of interrupts for 128 µs after each one, so the rate stays below roughly 7813 per second however fast requests arrive. An interval of zero bypasses the throttle entirely.

Requests that arrive while a gap is running are not lost. A sticky pending flag collects them, and one interrupt delivers them all when the gap expires. That interrupt starts a new gap. If nothing is pending at expiry, the block returns to idle and the next request fires at once. The interrupt output is a level that holds until the host acknowledges it.

The controller has three states. PS_IDLE means no gap is running. PS_ALIGN means an interrupt has just fired and the block is waiting for the first prescaler tick, so that a partial tick never counts toward the gap. PS_GAP means the countdown is running, one step per tick. The transitions are:

- fire_nz: PS_IDLE to PS_ALIGN when a request fires and the interval is non-zero.
- fire_zero: PS_IDLE to PS_IDLE when a request fires and the interval is zero.
- first_tick: PS_ALIGN to PS_GAP on the next tick.
- count: PS_GAP to PS_GAP on a tick before the count runs out.
- refire: PS_GAP to PS_ALIGN at expiry when a request is pending and the new interval is non-zero.
- drain: PS_GAP to PS_IDLE at expiry when nothing is pending, or when the pending interrupt fires with a zero interval.

Top module: `irq_pacer`

## Requirements
- R1: After reset the register reads 0 and `irq_out` is low.
- R2: A write stores `reg_wdata[15:0]` as the interval. `reg_rdata[15:0]` returns it on the cycle after the write, and `reg_rdata[31:16]` always reads 0.
- R3: With an interval of 0, a request raises `irq_out` on the next clock edge, even immediately after a previous interrupt was acknowledged.
- R4: With a non-zero interval and no gap running, a request raises `irq_out` on the next clock edge.
- R5: With interval I and a tick of T core cycles, the spacing d (in cycles) between successive assertions under continuous requests satisfies I·T < d ≤ (I+1)·T.
- R6: Any number of requests made during a gap, even single-cycle ones, produce exactly one interrupt when the gap ends. No interrupt appears before the gap ends.
- R7: If no request is pending when the gap ends, `irq_out` stays low. A later request then raises it on the next clock edge.
- R8: A write to the interval during a gap does not change the running gap. The new value governs the gap that starts at the next assertion.
- R9: `irq_out` stays high until `irq_ack` clears it on the next edge. A new interrupt firing in the same cycle as `irq_ack` keeps `irq_out` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for the interval register |
| reg_wdata | input | 32 | Write data; bits 15:0 are the interval in 256 ns units |
| reg_rdata | output | 32 | Register read data; bits 31:16 read 0 |
| irq_req | input | 1 | Interrupt request from cause logic, sampled every cycle |
| irq_ack | input | 1 | Host acknowledge; clears `irq_out` |
| irq_out | output | 1 | Throttled host interrupt level |

## Verification
Register readback appears one clock edge after the write strobe. The bench drives inputs just after a falling edge and samples at the following falling edge, so each check sees exactly one rising edge of latency. A request from idle, or under a zero interval, raises the output after that same single edge, and an acknowledge clears it after one edge. Gap results are due at a point that depends on prescaler phase, which the bench does not know. The bench therefore counts the cycles between observed assertions and checks that count against the window of more than I·T and at most (I+1)·T cycles, instead of at a fixed cycle.

// File: rtl/irq_pacer_pkg.sv
`timescale 1ns/1ps
package irq_pacer_pkg;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_ALIGN = 2'd1,
        PS_GAP   = 2'd2
    } pace_state_e;

endpackage

// File: rtl/irq_pacer_regs.sv
`timescale 1ns/1ps
module irq_pacer_regs #(
    parameter int REG_W = 32,
    parameter int IVAL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IVAL_W-1:0] wr_ival,
    output logic [REG_W-1:0]  rd_word,
    output logic [IVAL_W-1:0] ival
);

    localparam int PAD_W = REG_W - IVAL_W;

    logic [IVAL_W-1:0] ival_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ival_q <= '0;
        end else if (wr_en) begin
            ival_q <= wr_ival;
        end
    end

    assign ival    = ival_q;
    assign rd_word = {{PAD_W{1'b0}}, ival_q};

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_word[IVAL_W-1:0] == $past(wr_ival)));

endmodule

// File: rtl/irq_pacer_tick.sv
`timescale 1ns/1ps
module irq_pacer_tick #(
    parameter int TICK_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    generate
        if (TICK_CYCLES > 1) begin : g_div
            localparam int PW = $clog2(TICK_CYCLES);
            localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);
            logic [PW-1:0] div_q;

            always_ff @(posedge clk) begin
                if (!rst_n || div_q == LAST) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end

            assign tick = (div_q == LAST);

            assert_tick_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end else begin : g_pass
            assign tick = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/irq_pacer_fsm.sv
`timescale 1ns/1ps
module irq_pacer_fsm
    import irq_pacer_pkg::*;
#(
    parameter int IVAL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IVAL_W-1:0] ival,
    input  logic              tick,
    input  logic              irq_req,
    input  logic              irq_ack,
    output logic              irq_out
);

    localparam logic [IVAL_W-1:0] ONE = IVAL_W'(1);

    pace_state_e       state_q, state_d;
    logic [IVAL_W-1:0] cnt_q;
    logic              pend_q;
    logic              irq_q;
    logic              want;
    logic              expire;
    logic              fire;
    logic              ival_zero;

    assign want      = irq_req || pend_q;
    assign ival_zero = (ival == '0);
    assign expire    = (state_q == PS_GAP) && tick && (cnt_q == ONE);
    assign fire      = want && ((state_q == PS_IDLE) || expire);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE: begin
                if (fire && !ival_zero) begin
                    state_d = PS_ALIGN;
                end
            end
            PS_ALIGN: begin
                if (tick) begin
                    state_d = PS_GAP;
                end
            end
            PS_GAP: begin
                if (expire) begin
                    state_d = (fire && !ival_zero) ? PS_ALIGN : PS_IDLE;
                end
            end
            default: state_d = PS_IDLE;
        endcase
    end

    // Countdown, pending flag and output level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (fire) begin
                cnt_q <= ival;
            end else if (state_q == PS_GAP && tick) begin
                cnt_q <= cnt_q - ONE;
            end

            if (fire) begin
                pend_q <= 1'b0;
            end else if (state_q != PS_IDLE && irq_req) begin
                pend_q <= 1'b1;
            end

            if (fire) begin
                irq_q <= 1'b1;
            end else if (irq_ack) begin
                irq_q <= 1'b0;
            end
        end
    end

    assign irq_out = irq_q;

    assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_IDLE && ival_zero && irq_req) |=> irq_out);

    assert_idle_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_IDLE && irq_req) |=> irq_out);

    assert_align_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_ALIGN) |=> !$rose(irq_out));

    assert_gap_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_out) && $past(state_q) == PS_GAP) |-> $past(tick));

    assert_pend_drained_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> !pend_q);

    assert_cause_seen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past(irq_req || pend_q));

    assert_level_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !irq_ack) |=> irq_out);

endmodule

// File: rtl/irq_pacer.sv
`timescale 1ns/1ps
module irq_pacer #(
    parameter int TICK_CYCLES = 32,
    parameter int IVAL_W = 16,
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             irq_req,
    input  logic             irq_ack,
    output logic             irq_out
);

    logic [IVAL_W-1:0] ival;
    logic              tick;
    logic              unused_wr_hi;

    assign unused_wr_hi = ^reg_wdata[REG_W-1:IVAL_W];

    irq_pacer_regs #(
        .REG_W (REG_W),
        .IVAL_W(IVAL_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_we),
        .wr_ival(reg_wdata[IVAL_W-1:0]),
        .rd_word(reg_rdata),
        .ival   (ival)
    );

    irq_pacer_tick #(
        .TICK_CYCLES(TICK_CYCLES)
    ) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    irq_pacer_fsm #(
        .IVAL_W(IVAL_W)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .ival   (ival),
        .tick   (tick),
        .irq_req(irq_req),
        .irq_ack(irq_ack),
        .irq_out(irq_out)
    );

endmodule

// File: tb/irq_pacer_test.sv
`timescale 1ns/1ps
module irq_pacer_test;

    localparam int T = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_req = 1'b0;
    logic        irq_ack = 1'b0;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_pacer #(.TICK_CYCLES(T)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq_req  (irq_req),
        .irq_ack  (irq_ack),
        .irq_out  (irq_out)
    );

    task automatic step();
        @(negedge clk);
        cyc++;
    endtask

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] v);
        reg_we = 1'b1;
        reg_wdata = v;
        step();
        reg_we = 1'b0;
    endtask

    task automatic ack1();
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
    endtask

    task automatic settle();
        irq_req = 1'b0;
        irq_ack = 1'b1;
        repeat (20 * T) step();
        irq_ack = 1'b0;
        step();
    endtask

    task automatic wait_rise(input int limit, output int d);
        d = -1;
        for (int s = 1; s <= limit; s++) begin
            step();
            if (irq_out) begin
                d = s;
                break;
            end
        end
    endtask

    task automatic t_reset();
        chk(reg_rdata == 32'h0, "R1 rdata", int'(reg_rdata), 0);
        chk(irq_out == 1'b0, "R1 irq_out", int'(irq_out), 0);
    endtask

    task automatic t_register();
        wr(32'hABCD_1234);
        chk(reg_rdata == 32'h0000_1234, "R2 readback", int'(reg_rdata), 32'h1234);
        wr(32'hFFFF_FFFF);
        chk(reg_rdata == 32'h0000_FFFF, "R2 reserved zero", int'(reg_rdata), 32'hFFFF);
    endtask

    task automatic t_zero_and_ack();
        settle();
        wr(32'h0);
        irq_req = 1'b1;
        step();
        irq_req = 1'b0;
        chk(irq_out == 1'b1, "R3 bypass fire", int'(irq_out), 1);
        repeat (10) step();
        chk(irq_out == 1'b1, "R9 level held", int'(irq_out), 1);
        ack1();
        chk(irq_out == 1'b0, "R9 ack clears", int'(irq_out), 0);
        irq_req = 1'b1;
        step();
        irq_req = 1'b0;
        chk(irq_out == 1'b1, "R3 no gap after ack", int'(irq_out), 1);
        irq_req = 1'b1;
        irq_ack = 1'b1;
        step();
        irq_req = 1'b0;
        irq_ack = 1'b0;
        chk(irq_out == 1'b1, "R9 fire beats ack", int'(irq_out), 1);
        ack1();
        chk(irq_out == 1'b0, "R9 ack clears again", int'(irq_out), 0);
    endtask

    task automatic t_gap();
        int d;
        settle();
        wr(32'd3);
        irq_req = 1'b1;
        step();
        chk(irq_out == 1'b1, "R4 idle fire", int'(irq_out), 1);
        for (int k = 0; k < 2; k++) begin
            ack1();
            wait_rise(8 * T, d);
            if (d > 0) d = d + 1;
            chk(d > 3 * T && d <= 4 * T, "R5 gap spacing", d, 4 * T);
        end
        irq_req = 1'b0;
    endtask

    task automatic t_pending();
        int d;
        int extra;
        settle();
        wr(32'd2);
        irq_req = 1'b1;
        step();
        irq_req = 1'b0;
        chk(irq_out == 1'b1, "R4 first fire", int'(irq_out), 1);
        ack1();
        for (int k = 0; k < 3; k++) begin
            repeat (4) step();
            irq_req = 1'b1;
            step();
            irq_req = 1'b0;
        end
        chk(irq_out == 1'b0, "R6 held during gap", int'(irq_out), 0);
        wait_rise(4 * T, d);
        if (d > 0) d = d + 16;
        chk(d > 2 * T && d <= 3 * T, "R6 pending delivered", d, 3 * T);
        ack1();
        extra = 0;
        repeat (6 * T) begin
            step();
            if (irq_out) extra++;
        end
        chk(extra == 0, "R6 single delivery", extra, 0);
    endtask

    task automatic t_idle_after();
        int rises;
        settle();
        wr(32'd2);
        irq_req = 1'b1;
        step();
        irq_req = 1'b0;
        ack1();
        rises = 0;
        repeat (5 * T) begin
            step();
            if (irq_out) rises++;
        end
        chk(rises == 0, "R7 quiet expiry", rises, 0);
        irq_req = 1'b1;
        step();
        irq_req = 1'b0;
        chk(irq_out == 1'b1, "R7 fire from idle", int'(irq_out), 1);
    endtask

    task automatic t_write_in_gap();
        int d;
        settle();
        wr(32'd4);
        irq_req = 1'b1;
        step();
        chk(irq_out == 1'b1, "R4 fire before rewrite", int'(irq_out), 1);
        irq_ack = 1'b1;
        wr(32'd1);
        irq_ack = 1'b0;
        chk(reg_rdata == 32'd1, "R2 rewrite readback", int'(reg_rdata), 1);
        wait_rise(8 * T, d);
        if (d > 0) d = d + 1;
        chk(d > 4 * T && d <= 5 * T, "R8 running gap kept", d, 5 * T);
        ack1();
        wait_rise(4 * T, d);
        if (d > 0) d = d + 1;
        chk(d > T && d <= 2 * T, "R8 new value next gap", d, 2 * T);
        irq_req = 1'b0;
    endtask

    initial begin
        repeat (5) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_register();
        t_zero_and_ack();
        t_gap();
        t_pending();
        t_idle_after();
        t_write_in_gap();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1600000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule